// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Mid-Bit Start Validation

This block is the receive side of a classic single-buffered UART channel. It watches an asynchronous serial line, paced by a one-cycle enable that pulses at sixteen times the bit rate. A falling edge on the line is confirmed near the middle of the start bit, and a glitch that has already gone back high is dropped. The block then assembles a character of 5 to 8 data bits, sent least significant bit first. It can check an optional parity bit, in either normal or forced (stick) mode, and it checks the first stop bit.

Each finished character goes into a single holding register, and the error flags build up alongside it. The host drains the receiver with two one-cycle strobes. One strobe takes the character. The other takes the error flags. A character that completes while the holding register is still full is thrown away and flagged as an overrun. The character already held is left as it was.

Top module: `async_rx_unit`

## Requirements
- R1: After reset, `rx_ready`, `ovr_err`, `par_err`, `frm_err` and `brk_det` are all 0, and `rx_byte` is 0x00.
- R2: A start is taken only when the line goes from high to low. The line passes through a two-stage synchronizer first. The line is sampled again on the seventh `tick16` pulse after the pulse that first saw it low. If the line is high at that point, nothing is received and no output changes.
- R3: After the start bit, data bits are sampled every 16 ticks and stored least significant bit first. `len_sel` sets the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The data sits right-aligned in `rx_byte`, and the unused upper bits read 0.
- R4: With `par_en`=0 no parity bit is expected. The bit after the data is taken as the stop bit, and `par_err` is never set, whatever the data.
- R5: With `par_en`=1 and `par_stick`=0, `par_even`=1 expects the data bits plus the parity bit to hold an even number of ones, and `par_even`=0 expects an odd number. A mismatch sets `par_err`.
- R6: With `par_en`=1 and `par_stick`=1, the parity bit must equal the inverse of `par_even`. Otherwise `par_err` is set.
- R7: `frm_err` is set when the first stop bit is sampled low. Only one stop bit is ever checked.
- R8: `brk_det` is set, together with `frm_err`, when every sampled bit of the frame is low: start, data, parity if present, and stop. After that, a new start needs the line to go high again.
- R9: When a character is loaded into an empty holding register, `rx_ready` rises and `rx_byte` shows the new character.
- R10: A character that completes while `rx_ready` is 1 is dropped. `ovr_err` is set, and `rx_byte` and the other flags are left unchanged.
- R11: A one-cycle pulse on `rd_data` clears `rx_ready` on the next clock. `rx_byte` keeps its value.
- R12: A one-cycle pulse on `rd_status` clears `ovr_err`, `par_err`, `frm_err` and `brk_det` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| len_sel | input | 2 | Character length code (5 to 8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity (normal mode) / inverse of the fixed bit (stick mode) |
| par_stick | input | 1 | Stick parity mode |
| rd_data | input | 1 | Read strobe for the holding register |
| rd_status | input | 1 | Read strobe for the error flags |
| rx_byte | output | 8 | Held character, right-aligned |
| rx_ready | output | 1 | Holding register full |
| ovr_err | output | 1 | Overrun flag |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| brk_det | output | 1 | Break flag |

## Verification
A fault in the bit counter or the sample phase would show up within one frame. The frame would end with the wrong stop sample, so `frm_err` would be set, or it would end with data shifted by one position in `rx_byte`. Those outputs settle a few clocks after the middle of the stop bit. A fault in the parity sense or in the stick mode shows on `par_err` at that same point. A holding-register fault shows on the next character: either an overrun that replaces `rx_byte`, or one that leaves `ovr_err` low. The outputs are compared with a behavioural model on every clock of each idle gap, so any such fault is caught before the next frame begins.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_result_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       done,
    output rx_result_t result
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_LIM  = CW'(OSR / 2 - 2);
    localparam logic [CW-1:0] LAST_LIM = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e  st;
        logic [CW-1:0] cnt;
        logic [2:0] idx;
        logic [7:0] sh;
        logic       par;
        logic       zero;
        logic       perr;
        logic       armed;
        logic       done;
        rx_result_t res;
    } frm_t;

    frm_t q, d;
    logic [2:0] last_idx;
    logic       par_expect;

    always_comb begin
        last_idx   = 3'd4 + {1'b0, len_sel};
        par_expect = par_stick ? ~par_even : (par_even ? q.par : ~q.par);
        d          = q;
        d.done     = 1'b0;
        if (tick) begin
            case (q.st)
                S_IDLE: begin
                    if (rx) begin
                        d.armed = 1'b1;
                    end else if (q.armed) begin
                        d.st    = S_START;
                        d.cnt   = '0;
                        d.armed = 1'b0;
                    end
                end
                S_START: begin
                    if (q.cnt == MID_LIM) begin
                        d.cnt = '0;
                        if (!rx) begin
                            d.st   = S_DATA;
                            d.idx  = '0;
                            d.sh   = '0;
                            d.par  = 1'b0;
                            d.zero = 1'b1;
                            d.perr = 1'b0;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (q.cnt == LAST_LIM) begin
                        d.cnt  = '0;
                        d.sh   = {rx, q.sh[7:1]};
                        d.par  = q.par ^ rx;
                        d.zero = q.zero & ~rx;
                        if (q.idx == last_idx) d.st = par_en ? S_PAR : S_STOP;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (q.cnt == LAST_LIM) begin
                        d.cnt  = '0;
                        d.zero = q.zero & ~rx;
                        d.perr = (rx != par_expect);
                        d.st   = S_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (q.cnt == LAST_LIM) begin
                        d.cnt      = '0;
                        d.st       = S_IDLE;
                        d.done     = 1'b1;
                        d.res.data = q.sh >> (3'd3 - {1'b0, len_sel});
                        d.res.perr = q.perr;
                        d.res.ferr = ~rx;
                        d.res.brk  = q.zero & ~rx;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done   = q.done;
    assign result = q.res;

    // R2: the start check never waits past the mid-bit sample point
    p_start_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_START) |-> (q.cnt <= MID_LIM));

    // R2: a high line at the mid-start sample drops back to idle
    p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_START && tick && q.cnt == MID_LIM && rx) |=> (q.st == S_IDLE && !q.done));

    // R8: a break result always carries a framing error
    p_break_frames_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.res.brk) |-> q.res.ferr);

    // R4: without parity the parity state is never entered
    p_no_par_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DATA && !par_en && tick && q.cnt == LAST_LIM && q.idx == last_idx)
        |=> (q.st == S_STOP));

    // R3: a completed frame is one pulse, never back to back
    p_single_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  rx_result_t result,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] data,
    output logic       ready,
    output logic       ovr,
    output logic       perr,
    output logic       ferr,
    output logic       brk
);
    typedef struct packed {
        logic [7:0] data;
        logic       ready;
        logic       ovr;
        logic       perr;
        logic       ferr;
        logic       brk;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (rd_data) d.ready = 1'b0;
        if (rd_status) begin
            d.ovr  = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
            d.brk  = 1'b0;
        end
        if (done) begin
            if (q.ready && !rd_data) begin
                d.ovr = 1'b1;
            end else begin
                d.data  = result.data;
                d.ready = 1'b1;
                d.perr  = d.perr | result.perr;
                d.ferr  = d.ferr | result.ferr;
                d.brk   = d.brk  | result.brk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data  = q.data;
    assign ready = q.ready;
    assign ovr   = q.ovr;
    assign perr  = q.perr;
    assign ferr  = q.ferr;
    assign brk   = q.brk;

    // R10: an overrun keeps the held character
    p_overrun_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.ready && !rd_data) |=> ($stable(q.data) && q.ovr && q.ready));

    // R9: loading an empty register raises ready
    p_load_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !q.ready) |=> q.ready);

    // R11: a data read with no new character empties the register
    p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> (!q.ready && $stable(q.data)));

    // R12: a status read with no new character clears every flag
    p_status_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !done) |=> (!q.ovr && !q.perr && !q.ferr && !q.brk));
endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_byte,
    output logic       rx_ready,
    output logic       ovr_err,
    output logic       par_err,
    output logic       frm_err,
    output logic       brk_det
);
    logic       rx_s;
    logic       frm_done;
    rx_result_t frm_res;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rxd),
        .sync_out (rx_s)
    );

    srx_framer #(.OSR(OSR)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .rx        (rx_s),
        .len_sel   (len_sel),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .done      (frm_done),
        .result    (frm_res)
    );

    srx_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (frm_done),
        .result    (frm_res),
        .rd_data   (rd_data),
        .rd_status (rd_status),
        .data      (rx_byte),
        .ready     (rx_ready),
        .ovr       (ovr_err),
        .perr      (par_err),
        .ferr      (frm_err),
        .brk       (brk_det)
    );
endmodule

// File: tb/sim_async_rx_unit.sv
module sim_async_rx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] len_sel = 2'b11;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_stick = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_ready, ovr_err, par_err, frm_err, brk_det;

    int total = 0;
    int bad = 0;
    bit cmp_en = 0;

    // behavioural model state
    logic [7:0] m_data = 8'h00;
    bit m_ready = 0, m_ovr = 0, m_perr = 0, m_ferr = 0, m_brk = 0;

    always #2.5 clk = ~clk;

    int tdiv = 0;
    always @(posedge clk) begin
        tdiv   <= (tdiv + 1) % 2;
        tick16 <= (tdiv == 0);
    end

    async_rx_unit u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .len_sel(len_sel), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .rd_data(rd_data), .rd_status(rd_status),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .ovr_err(ovr_err),
        .par_err(par_err), .frm_err(frm_err), .brk_det(brk_det)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            check(rx_byte == m_data,  "R3 rx_byte",  rx_byte,  m_data);
            check(rx_ready == m_ready, "R9 rx_ready", rx_ready, m_ready);
            check(ovr_err == m_ovr,   "R10 ovr_err", ovr_err,  m_ovr);
            check(par_err == m_perr,  "R5 par_err",  par_err,  m_perr);
            check(frm_err == m_ferr,  "R7 frm_err",  frm_err,  m_ferr);
            check(brk_det == m_brk,   "R8 brk_det",  brk_det,  m_brk);
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive_bit(input logic v);
        rxd = v;
        wait_clks(32);
    endtask

    // expected parity error from the rules alone
    function automatic bit exp_perr(input logic [7:0] v, input int nbits, input logic pbit);
        int ones = 0;
        logic want;
        for (int i = 0; i < nbits; i++) ones += v[i];
        if (par_stick) want = ~par_even;
        else if (par_even) want = logic'(ones % 2);
        else want = logic'(1 - ones % 2);
        return pbit != want;
    endfunction

    task automatic send_frame(input logic [7:0] v, input logic pbit, input logic stopv);
        int nbits = 5 + int'(len_sel);
        logic [7:0] masked = v & 8'((1 << nbits) - 1);
        bit pe = par_en ? exp_perr(v, nbits, pbit) : 0;
        bit allz = (masked == 0) && (!par_en || pbit == 0) && (stopv == 0);
        cmp_en = 0;
        drive_bit(1'b0);
        for (int i = 0; i < nbits; i++) drive_bit(v[i]);
        if (par_en) drive_bit(pbit);
        drive_bit(stopv);
        rxd = 1'b1;
        wait_clks(20);
        if (m_ready) m_ovr = 1;
        else begin
            m_data  = masked;
            m_ready = 1;
            m_perr  = m_perr | pe;
            m_ferr  = m_ferr | (stopv == 0);
            m_brk   = m_brk | allz;
        end
        cmp_en = 1;
        wait_clks(4);
    endtask

    task automatic read_data();
        cmp_en = 0;
        rd_data = 1; wait_clks(1); rd_data = 0;
        m_ready = 0;
        cmp_en = 1;
        wait_clks(3);
    endtask

    task automatic read_status();
        cmp_en = 0;
        rd_status = 1; wait_clks(1); rd_status = 0;
        m_ovr = 0; m_perr = 0; m_ferr = 0; m_brk = 0;
        cmp_en = 1;
        wait_clks(3);
    endtask

    initial begin
        #1;
        wait_clks(4);
        rst_n = 1;
        wait_clks(40);
        // R1 reset state
        check(rx_ready == 0 && ovr_err == 0 && par_err == 0 && frm_err == 0 && brk_det == 0,
              "R1 flags after reset", {rx_ready, ovr_err, par_err, frm_err, brk_det}, 0);
        check(rx_byte == 8'h00, "R1 rx_byte after reset", rx_byte, 0);
        cmp_en = 1;

        // R3 eight bits, LSB first
        len_sel = 2'b11; send_frame(8'hA5, 1'b0, 1'b1);
        check(rx_byte == 8'hA5 && rx_ready, "R3 8-bit char", rx_byte, 8'hA5);
        read_data();
        check(rx_ready == 0 && rx_byte == 8'hA5, "R11 ready cleared, data kept", rx_ready, 0);

        // R3 five, six and seven bits, upper bits zero
        len_sel = 2'b00; send_frame(8'hF3, 1'b0, 1'b1);
        check(rx_byte == 8'h13, "R3 5-bit char", rx_byte, 8'h13);
        read_data();
        len_sel = 2'b01; send_frame(8'hED, 1'b0, 1'b1);
        check(rx_byte == 8'h2D, "R3 6-bit char", rx_byte, 8'h2D);
        read_data();
        len_sel = 2'b10; send_frame(8'hC1, 1'b0, 1'b1);
        check(rx_byte == 8'h41, "R3 7-bit char", rx_byte, 8'h41);
        read_data();

        // R2 short low glitch is not a start
        cmp_en = 0;
        rxd = 1'b0; wait_clks(8); rxd = 1'b1;
        wait_clks(400);
        cmp_en = 1;
        wait_clks(2);
        check(rx_ready == 0 && frm_err == 0, "R2 glitch rejected", {rx_ready, frm_err}, 0);

        // R5 even parity, good then bad
        len_sel = 2'b11; par_en = 1; par_even = 1; par_stick = 0;
        send_frame(8'h07, 1'b1, 1'b1);
        check(par_err == 0, "R5 even parity good", par_err, 0);
        read_data();
        send_frame(8'h07, 1'b0, 1'b1);
        check(par_err == 1, "R5 even parity bad", par_err, 1);
        read_data();
        read_status();
        check(par_err == 0, "R12 status read clears parity", par_err, 0);

        // R5 odd parity
        par_even = 0;
        send_frame(8'h03, 1'b1, 1'b1);
        check(par_err == 0, "R5 odd parity good", par_err, 0);
        read_data();

        // R6 stick parity: bit must be inverse of par_even
        par_stick = 1; par_even = 0;
        send_frame(8'h01, 1'b1, 1'b1);
        check(par_err == 0, "R6 stick one good", par_err, 0);
        read_data();
        par_even = 1;
        send_frame(8'h01, 1'b1, 1'b1);
        check(par_err == 1, "R6 stick zero bad", par_err, 1);
        read_data(); read_status();

        // R4 no parity: odd data count, never a parity error
        par_en = 0; par_stick = 0;
        send_frame(8'h01, 1'b0, 1'b1);
        check(par_err == 0 && frm_err == 0, "R4 parity ignored", {par_err, frm_err}, 0);
        read_data();

        // R7 stop bit low
        send_frame(8'h5A, 1'b0, 1'b0);
        check(frm_err == 1 && brk_det == 0, "R7 framing error", {frm_err, brk_det}, 2);
        read_data(); read_status();

        // R8 break frame
        send_frame(8'h00, 1'b0, 1'b0);
        check(brk_det == 1 && frm_err == 1 && rx_byte == 0, "R8 break", {brk_det, frm_err}, 3);
        read_data(); read_status();
        send_frame(8'h3C, 1'b0, 1'b1);
        check(rx_byte == 8'h3C && brk_det == 0, "R8 receive resumes after break", rx_byte, 8'h3C);

        // R10 overrun keeps old character
        send_frame(8'h99, 1'b0, 1'b1);
        check(ovr_err == 1 && rx_byte == 8'h3C, "R10 overrun keeps old", rx_byte, 8'h3C);
        read_status();
        check(ovr_err == 0, "R12 status read clears overrun", ovr_err, 0);
        read_data();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule